// File: doc/BRIEF.md
# Two-Class Dual-Issue Slip Controller

This block sits between instruction fetch and the execution units of an in-order core that can issue two instructions per cycle. Each cycle it is offered one aligned pair of pre-decoded instructions. Slot 0 is the older instruction and slot 1 the younger. Each slot carries a valid bit, a one-bit class tag (floating-point ALU or other) and a mask of the long-latency units it needs. The block raises one issue strobe per slot. It accepts the pair, which lets fetch advance, once every valid slot of the pair has issued.

Pairing depends only on the class tag. Two instructions of different classes never need a dependency check between them, so they issue together. Two instructions of the same class issue one per cycle, the older one first. If a slot needs a long-latency unit that reports busy, that slot waits. Every younger slot waits behind it, so nothing is reordered and nothing is speculated.

The pair arrives on a valid/ready stream. `pair_valid` offers a pair and `pair_ready` accepts it. While `pair_valid` is high and `pair_ready` is low, fetch must hold every slot field steady. That is the back-pressure of a slip. A pair is consumed on a clock edge where both are high.

Top module: `dual_issue_slip`

## Requirements
- R1: After reset, with no pair offered, both issue strobes and `pair_ready` are low.
- R2: At most one instruction of each class issues per cycle. Both strobes are high in the same cycle only if `slot_cls[0]` differs from `slot_cls[1]` (encoding: 1 = floating-point ALU, 0 = other).
- R3: If both slots are valid, share a class and are not blocked, slot 0 issues in the first cycle and slot 1 issues in the next cycle. `pair_ready` is high only in that second cycle.
- R4: If both slots are valid, differ in class and are not blocked, both issue in the same cycle and `pair_ready` is high in that cycle.
- R5: A slot whose valid bit is 0 never issues. A pair with `slot_vld` = 2'b10 (only slot 1 valid, as for a branch target in slot 1) issues only slot 1 and is accepted in that cycle.
- R6: A slot is blocked while any unit it needs is busy. The need and busy masks use bit 0 for the floating-point divide/square-root unit and bit 1 for the integer multiply/divide unit. A busy unit that the slot does not need has no effect. A blocked slot issues in the first cycle after its needed units are no longer busy.
- R7: Slot 1 never issues while a valid slot 0 of the same pair has neither issued earlier nor issues in the same cycle.
- R8: Each slot issues at most once per pair. `pair_ready` is high only when every valid slot has issued, in the current cycle or in an earlier one.
- R9: With `pair_valid` low, no strobe and no `pair_ready` are raised, whatever the slot fields hold.
- R10: An offered pair with no valid slot is accepted in its first cycle without any issue strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | A fetched pair is offered |
| pair_ready | output | 1 | The pair is finished; fetch may advance |
| slot_vld | input | 2 | Per-slot valid bits, bit 0 = older slot |
| slot_cls | input | 2 | Per-slot class, 1 = floating-point ALU |
| slot0_need | input | NUNIT | Long-latency units needed by slot 0 |
| slot1_need | input | NUNIT | Long-latency units needed by slot 1 |
| unit_busy | input | NUNIT | Busy flags of the long-latency units |
| issue | output | 2 | Issue strobe per slot |

## Verification
The assertions assume that fetch honours the stream rule: slot fields stay fixed from the first cycle a pair is offered until the cycle it is accepted. The internal issued-slot record of the checker is only meaningful under that rule. The bench changes slot fields and `pair_valid` only after the cycle in which it expects `pair_ready` high. Busy flags change freely, because the block must react to them in any cycle. The bench also keeps `pair_valid` low whenever it presents a valid slot mask that it does not mean to be consumed.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int NSLOT = 2;

  typedef enum logic {
    CLS_OTHER = 1'b0,
    CLS_FPALU = 1'b1
  } issue_cls_e;
endpackage

// File: rtl/dis_slot_gate.sv
module dis_slot_gate #(
  parameter int NUNIT = 2
) (
  input  logic             pending,
  input  logic [NUNIT-1:0] need,
  input  logic [NUNIT-1:0] busy,
  output logic             can_go
);
  logic [NUNIT-1:0] clash;

  always_comb begin
    clash  = need & busy;
    can_go = pending && (clash == '0);
  end
endmodule

// File: rtl/dis_pair_track.sv
module dis_pair_track #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] fire,
  input  logic             advance,
  output logic [NSLOT-1:0] done
);
  always_ff @(posedge clk) begin
    if (!rst_n)       done <= '0;
    else if (advance) done <= '0;
    else              done <= done | fire;
  end
endmodule

// File: rtl/dual_issue_slip.sv
module dual_issue_slip #(
  parameter int NUNIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_valid,
  output logic             pair_ready,
  input  logic [1:0]       slot_vld,
  input  logic [1:0]       slot_cls,
  input  logic [NUNIT-1:0] slot0_need,
  input  logic [NUNIT-1:0] slot1_need,
  input  logic [NUNIT-1:0] unit_busy,
  output logic [1:0]       issue
);
  import dis_pkg::*;

  logic [NSLOT-1:0] done;
  logic [NSLOT-1:0] pending;
  logic [NSLOT-1:0] can_go;
  logic [NUNIT-1:0] need [NSLOT];
  logic             cls_split;

  assign need[0] = slot0_need;
  assign need[1] = slot1_need;

  always_comb pending = {NSLOT{pair_valid}} & slot_vld & ~done;

  for (genvar s = 0; s < NSLOT; s++) begin : g_gate
    dis_slot_gate #(.NUNIT(NUNIT)) gate_i (
      .pending (pending[s]),
      .need    (need[s]),
      .busy    (unit_busy),
      .can_go  (can_go[s])
    );
  end

  always_comb begin
    cls_split  = issue_cls_e'(slot_cls[0]) != issue_cls_e'(slot_cls[1]);
    issue[0]   = can_go[0];
    issue[1]   = can_go[1] && (!pending[0] || (issue[0] && cls_split));
    pair_ready = pair_valid && ((pending & ~issue) == '0);
  end

  dis_pair_track #(.NSLOT(NSLOT)) track_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (issue),
    .advance (pair_ready),
    .done    (done)
  );
endmodule

// File: rtl/dual_issue_slip_chk.sv
module dual_issue_slip_chk #(
  parameter int NUNIT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pair_valid,
  input logic             pair_ready,
  input logic [1:0]       slot_vld,
  input logic [1:0]       slot_cls,
  input logic [NUNIT-1:0] slot0_need,
  input logic [NUNIT-1:0] slot1_need,
  input logic [NUNIT-1:0] unit_busy,
  input logic [1:0]       issue
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                       seen <= '0;
    else if (pair_valid && pair_ready) seen <= '0;
    else                               seen <= seen | issue;
  end

  assert_one_per_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue == 2'b11) |-> (slot_cls[0] != slot_cls[1]));

  assert_no_invalid_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue != 2'b00) |-> ((issue & ~slot_vld) == 2'b00));

  assert_busy_blocks_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue[0] |-> ((slot0_need & unit_busy) == '0));

  assert_busy_blocks_slot1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue[1] |-> ((slot1_need & unit_busy) == '0));

  assert_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue[1] && slot_vld[0]) |-> (issue[0] || seen[0]));

  assert_single_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue != 2'b00) |-> ((issue & seen) == 2'b00));

  assert_ready_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |-> ((slot_vld & ~(seen | issue)) == 2'b00));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> (issue == 2'b00 && !pair_ready));
endmodule

bind dual_issue_slip dual_issue_slip_chk #(.NUNIT(NUNIT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pair_valid (pair_valid),
  .pair_ready (pair_ready),
  .slot_vld   (slot_vld),
  .slot_cls   (slot_cls),
  .slot0_need (slot0_need),
  .slot1_need (slot1_need),
  .unit_busy  (unit_busy),
  .issue      (issue)
);

// File: tb/dual_issue_slip_tb_top.sv
module dual_issue_slip_tb_top;
  localparam int NUNIT = 2;

  typedef struct {
    logic [1:0] iss;
    logic       rdy;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pair_valid = 1'b0;
  logic             pair_ready;
  logic [1:0]       slot_vld = '0;
  logic [1:0]       slot_cls = '0;
  logic [NUNIT-1:0] slot0_need = '0;
  logic [NUNIT-1:0] slot1_need = '0;
  logic [NUNIT-1:0] unit_busy = '0;
  logic [1:0]       issue;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   stim_done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  dual_issue_slip #(.NUNIT(NUNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .slot_vld(slot_vld), .slot_cls(slot_cls), .slot0_need(slot0_need),
    .slot1_need(slot1_need), .unit_busy(unit_busy), .issue(issue)
  );

  task automatic step(input logic pv, input logic [1:0] vld, input logic [1:0] cls,
                      input logic [1:0] n0, input logic [1:0] n1, input logic [1:0] busy,
                      input logic [1:0] e_iss, input logic e_rdy, input string tag);
    exp_t e;
    @(negedge clk);
    pair_valid = pv; slot_vld = vld; slot_cls = cls;
    slot0_need = n0; slot1_need = n1; unit_busy = busy;
    e.iss = e_iss; e.rdy = e_rdy; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_vec++;
        if (issue !== e.iss || pair_ready !== e.rdy) begin
          n_bad++;
          $display("FAIL %s: issue=%b ready=%b expected issue=%b ready=%b",
                   e.tag, issue, pair_ready, e.iss, e.rdy);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!stim_done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    step(0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, "R1 idle during reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, "R1 idle after reset");
    // R4 mixed classes issue together
    step(1, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11, 1, "R4 mixed pair");
    step(1, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, 2'b11, 1, "R4 mixed pair swapped");
    // R3 same class, both other, then both fp
    step(1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 0, "R3 same class first cycle");
    step(1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1, "R3 same class second cycle");
    step(1, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b01, 0, "R3 fp pair first cycle");
    step(1, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b10, 1, "R3 fp pair second cycle");
    // R5 single valid slots
    step(1, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1, "R5 slot1 only");
    step(1, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b01, 1, "R5 slot0 only");
    // R6/R7 slot0 blocked by fp divider, slot1 waits behind it
    step(1, 2'b11, 2'b10, 2'b01, 2'b00, 2'b01, 2'b00, 0, "R7 slot0 blocked holds slot1");
    step(1, 2'b11, 2'b10, 2'b01, 2'b00, 2'b01, 2'b00, 0, "R6 still blocked");
    step(1, 2'b11, 2'b10, 2'b01, 2'b00, 2'b00, 2'b11, 1, "R6 released");
    // R6 unneeded busy unit has no effect
    step(1, 2'b11, 2'b10, 2'b00, 2'b00, 2'b11, 2'b11, 1, "R6 unneeded busy ignored");
    // R8 slot1 blocked by int mul/div; slot0 must not reissue
    step(1, 2'b11, 2'b01, 2'b00, 2'b10, 2'b10, 2'b01, 0, "R8 slot0 goes slot1 blocked");
    step(1, 2'b11, 2'b01, 2'b00, 2'b10, 2'b10, 2'b00, 0, "R8 no reissue of slot0");
    step(1, 2'b11, 2'b01, 2'b00, 2'b10, 2'b00, 2'b10, 1, "R8 slot1 completes pair");
    // R10 empty pair
    step(1, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 1, "R10 empty pair accepted");
    // R9 no pair offered
    step(0, 2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 0, "R9 pair_valid low");
    step(0, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, "R9 pair_valid low again");
    // R2 same-class pair with busy on slot1: serial
    step(1, 2'b11, 2'b11, 2'b00, 2'b01, 2'b01, 2'b01, 0, "R2 same class slot0 only");
    step(1, 2'b11, 2'b11, 2'b00, 2'b01, 2'b00, 2'b10, 1, "R2 slot1 after release");
    step(0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 0, "R1 idle at end");
    @(negedge clk);
    @(negedge clk);
    stim_done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule